// File: doc/BRIEF.md
# Vectored Interrupt Controller with Indirect Source Access

This controller gathers up to 128 interrupt inputs and raises one synchronous request towards a processor. Sources are not configured through wide per-source bit vectors. Software first writes a source number into a select register. Every later access to the per-source mode and vector storage, and every enable, disable, clear or force command, then applies to that one source.

Each source has a 3-bit priority and a trigger type. The type is either a level (active low or high) or an edge (falling or rising). Among the sources that are enabled, pending and above the current nesting level, the block picks a winner. On a tie in priority, the lowest source number wins. Reading the acknowledge port returns the winner's vector, or the programmable spurious vector when there is no winner. An acknowledge that finds a winner pushes that source and its priority onto an eight-entry hardware nesting stack. A write of any value to the end-of-interrupt port pops the stack. While the stack holds an entry, only sources of strictly higher priority than the top entry may raise the request again.

Top module: `vec_intc`

## Requirements
- R1: The select register at offset 0x00 keeps the low 7 bits of the written value and reads them back. All per-source accesses and commands act on the source it names.
- R2: The mode word at 0x04 holds the priority in bits [2:0] (7 is highest) and the trigger in bits [6:5], encoded as 00 level-low, 01 level-high, 10 falling edge and 11 rising edge. The mode word reads back in that layout. The per-source vector at 0x08 is a read/write 32-bit value.
- R3: Writing a value with bit 0 set to 0x40 enables the selected source, and the same write to 0x44 masks it. The selected source's enable reads back at 0x30 bit 0, and other sources are not affected.
- R4: Writing a value with bit 0 set to 0x4C forces the selected source pending, and the same write to 0x48 clears its latched pending state.
- R5: An edge source latches pending on the configured edge and stays pending until cleared or acknowledged. A level source is pending exactly while its input is at the active level.
- R6: irqOut is high one cycle after an enabled pending source exists whose priority is above the stack top (any priority when the stack is empty). A read of 0x10 returns that source's vector. The highest priority wins, and on a tie the lowest source number wins.
- R7: A read of 0x10 with no eligible source returns the spurious vector (read/write at 0x3C) and leaves the stack unchanged.
- R8: A read of 0x10 that finds a winner pushes it onto the stack and clears its latched pending bit. irqOut is low in the following cycle. 0x18 returns the source number on the stack top, or 0 when the stack is empty. 0x34 returns irqOut in bit 0 and the stack depth in bits [11:8].
- R9: A write of any value to 0x38 pops one stack entry. On an empty stack it has no effect. The stack holds eight levels, so eight such writes always empty it.
- R10: After reset, every source is disabled, not pending, at priority 0 with a level-high trigger, and has vector 0. The stack is empty, irqOut is low, the select register reads 0, the spurious vector reads 0, and the debug word at 0x6C reads 0.
- R11: While the stack holds an entry of priority p, a pending source of priority p or lower does not raise irqOut. It raises irqOut again once the entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 128 | Interrupt inputs, synchronous to clk |
| busSel | input | 1 | Register access valid this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The state that is hardest to reach from the ports is a full stack of eight entries. Reaching it needs eight acknowledges in strictly rising priority, each made only after the previous acknowledge has raised the threshold. The stimulus builds it one level at a time: it forces a source of the next priority pending and then acknowledges it, so the eighth acknowledge lands at priority 7. It then drains the stack with end-of-interrupt writes, adding one extra write on the empty stack. Seeded random rounds scatter sources of random priority and enable state over the whole index range. Each round is checked against a bench model of the winner rules.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int PRIO_W = 3;

  localparam logic [ADDR_W-1:0] A_SEL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_MODE  = 8'h04;
  localparam logic [ADDR_W-1:0] A_VEC   = 8'h08;
  localparam logic [ADDR_W-1:0] A_ACK   = 8'h10;
  localparam logic [ADDR_W-1:0] A_CUR   = 8'h18;
  localparam logic [ADDR_W-1:0] A_MASKV = 8'h30;
  localparam logic [ADDR_W-1:0] A_CORE  = 8'h34;
  localparam logic [ADDR_W-1:0] A_EOI   = 8'h38;
  localparam logic [ADDR_W-1:0] A_SPUR  = 8'h3C;
  localparam logic [ADDR_W-1:0] A_EN    = 8'h40;
  localparam logic [ADDR_W-1:0] A_DIS   = 8'h44;
  localparam logic [ADDR_W-1:0] A_CLR   = 8'h48;
  localparam logic [ADDR_W-1:0] A_SET   = 8'h4C;
  localparam logic [ADDR_W-1:0] A_DBG   = 8'h6C;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_HIGH = 2'b01,
    TRG_FALL = 2'b10,
    TRG_RISE = 2'b11
  } trig_e;

  typedef struct packed {
    logic modeWr;
    logic vecWr;
    logic enCmd;
    logic disCmd;
    logic clrCmd;
    logic setCmd;
    logic ack;
    logic eoi;
  } strobe_t;
endpackage

// File: rtl/vec_intc_ctl.sv
module vec_intc_ctl
  import vec_intc_pkg::*;
#(
  parameter int NSRC  = 128,
  parameter int DEPTH = 8,
  localparam int SEL_W = $clog2(NSRC),
  localparam int DW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output strobe_t           stb,
  output logic [SEL_W-1:0]  selIdx,
  output logic [DATA_W-1:0] spurVec,
  input  logic [7:0]        selMode,
  input  logic [DATA_W-1:0] selVec,
  input  logic              selEn,
  input  logic              winValid,
  input  logic [DATA_W-1:0] winVec,
  input  logic [SEL_W-1:0]  curSrc,
  input  logic [DW-1:0]     depth,
  input  logic              irqOut
);
  logic wrEn, rdEn;
  logic [1:0] dbgReg;

  assign wrEn = busSel && busWr;
  assign rdEn = busSel && !busWr;

  // bus decode into one-cycle strobes for the datapath
  always_comb begin
    stb        = '0;
    stb.modeWr = wrEn && (busAddr == A_MODE);
    stb.vecWr  = wrEn && (busAddr == A_VEC);
    stb.enCmd  = wrEn && (busAddr == A_EN)  && busWdata[0];
    stb.disCmd = wrEn && (busAddr == A_DIS) && busWdata[0];
    stb.clrCmd = wrEn && (busAddr == A_CLR) && busWdata[0];
    stb.setCmd = wrEn && (busAddr == A_SET) && busWdata[0];
    stb.ack    = rdEn && (busAddr == A_ACK);
    stb.eoi    = wrEn && (busAddr == A_EOI);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx  <= '0;
      spurVec <= '0;
      dbgReg  <= '0;
    end else if (wrEn) begin
      if (busAddr == A_SEL)  selIdx  <= busWdata[SEL_W-1:0];
      if (busAddr == A_SPUR) spurVec <= busWdata;
      if (busAddr == A_DBG)  dbgReg  <= busWdata[1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_SEL:   busRdata[SEL_W-1:0] = selIdx;
      A_MODE:  busRdata[7:0] = selMode;
      A_VEC:   busRdata = selVec;
      A_ACK:   busRdata = winValid ? winVec : spurVec;
      A_CUR:   busRdata[SEL_W-1:0] = curSrc;
      A_MASKV: busRdata[0] = selEn;
      A_CORE: begin
        busRdata[0]      = irqOut;
        busRdata[8 +: DW] = depth;
      end
      A_SPUR:  busRdata = spurVec;
      A_DBG:   busRdata[1:0] = dbgReg;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/vec_intc_dp.sv
module vec_intc_dp
  import vec_intc_pkg::*;
#(
  parameter int NSRC  = 128,
  parameter int DEPTH = 8,
  localparam int SEL_W = $clog2(NSRC),
  localparam int DW    = $clog2(DEPTH + 1),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SEL_W-1:0]  selIdx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   srcIn,
  output logic [7:0]        selMode,
  output logic [DATA_W-1:0] selVec,
  output logic              selEn,
  output logic              winValid,
  output logic [DATA_W-1:0] winVec,
  output logic [SEL_W-1:0]  curSrc,
  output logic [DW-1:0]     depth,
  output logic              irqOut
);
  logic [PRIO_W-1:0] pri  [NSRC];
  trig_e             trig [NSRC];
  logic [DATA_W-1:0] vec  [NSRC];
  logic [NSRC-1:0]   en, latch, latchNxt, prev, edgeHit, lvlHit, pend, elig;

  logic [SEL_W-1:0]  stkSrc [DEPTH];
  logic [PRIO_W-1:0] stkPri [DEPTH];
  logic              stkEmpty;
  logic [DW-1:0]     depthM1;
  logic [PW-1:0]     topIdx;
  logic [PRIO_W-1:0] topPri;

  logic [SEL_W-1:0]  winIdx;
  logic [PRIO_W-1:0] winPri;
  logic              doAck, doPop;

  assign stkEmpty = (depth == '0);
  assign depthM1  = depth - DW'(1);
  assign topIdx   = depthM1[PW-1:0];
  assign topPri   = stkPri[topIdx];
  assign curSrc   = stkEmpty ? '0 : stkSrc[topIdx];

  // per-source trigger decode and eligibility
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign edgeHit[g] = ((trig[g] == TRG_RISE) &&  srcIn[g] && !prev[g]) ||
                        ((trig[g] == TRG_FALL) && !srcIn[g] &&  prev[g]);
    assign lvlHit[g]  = ((trig[g] == TRG_HIGH) &&  srcIn[g]) ||
                        ((trig[g] == TRG_LOW)  && !srcIn[g]);
    assign pend[g]    = latch[g] || lvlHit[g];
    assign elig[g]    = en[g] && pend[g] && (stkEmpty || (pri[g] > topPri));
  end

  // strict compare keeps the lowest index on a priority tie
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPri   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!winValid || (pri[i] > winPri))) begin
        winValid = 1'b1;
        winIdx   = SEL_W'(i);
        winPri   = pri[i];
      end
    end
  end

  assign winVec  = vec[winIdx];
  assign selMode = {1'b0, trig[selIdx], 2'b00, pri[selIdx]};
  assign selVec  = vec[selIdx];
  assign selEn   = en[selIdx];

  assign doAck = stb.ack && winValid && (depth < DW'(DEPTH));
  assign doPop = stb.eoi && !stkEmpty;

  always_comb begin
    latchNxt = latch | edgeHit;
    if (stb.setCmd) latchNxt[selIdx] = 1'b1;
    if (stb.clrCmd) latchNxt[selIdx] = 1'b0;
    if (doAck)      latchNxt[winIdx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSRC; i++) begin
        pri[i]  <= '0;
        trig[i] <= TRG_HIGH;
        vec[i]  <= '0;
      end
      en    <= '0;
      latch <= '0;
      prev  <= '0;
    end else begin
      prev  <= srcIn;
      latch <= latchNxt;
      if (stb.modeWr) begin
        pri[selIdx]  <= wdata[PRIO_W-1:0];
        trig[selIdx] <= trig_e'(wdata[6:5]);
      end
      if (stb.vecWr)  vec[selIdx] <= wdata;
      if (stb.enCmd)  en[selIdx]  <= 1'b1;
      if (stb.disCmd) en[selIdx]  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth  <= '0;
      irqOut <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        stkSrc[i] <= '0;
        stkPri[i] <= '0;
      end
    end else begin
      irqOut <= winValid && !stb.ack;
      if (doAck) begin
        stkSrc[depth[PW-1:0]] <= winIdx;
        stkPri[depth[PW-1:0]] <= winPri;
        depth <= depth + DW'(1);
      end else if (doPop) begin
        depth <= depthM1;
      end
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NSRC  = 128,
  parameter int DEPTH = 8,
  localparam int SEL_W = $clog2(NSRC),
  localparam int DW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  strobe_t           stb;
  logic [SEL_W-1:0]  selIdx, curSrc;
  logic [DATA_W-1:0] spurVec, selVec, winVec;
  logic [7:0]        selMode;
  logic              selEn, winValid;
  logic [DW-1:0]     stkDepth;

  vec_intc_ctl #(.NSRC(NSRC), .DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .stb(stb), .selIdx(selIdx), .spurVec(spurVec),
    .selMode(selMode), .selVec(selVec), .selEn(selEn),
    .winValid(winValid), .winVec(winVec), .curSrc(curSrc),
    .depth(stkDepth), .irqOut(irqOut)
  );

  vec_intc_dp #(.NSRC(NSRC), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .selIdx(selIdx), .wdata(busWdata),
    .srcIn(srcIn), .selMode(selMode), .selVec(selVec), .selEn(selEn),
    .winValid(winValid), .winVec(winVec), .curSrc(curSrc),
    .depth(stkDepth), .irqOut(irqOut)
  );
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
  import vec_intc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic [DW-1:0]     depth,
  input logic              winValid,
  input logic [DATA_W-1:0] spurVec
);
  logic ackRd, eoiWr;
  assign ackRd = busSel && !busWr && (busAddr == A_ACK);
  assign eoiWr = busSel && busWr && (busAddr == A_EOI);

  // R9 stack never exceeds its eight levels
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DW'(DEPTH));

  // R8 request drops in the cycle after an acknowledge read
  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackRd |=> !irqOut);

  // R8 a successful acknowledge grows the stack by one
  p_ack_push_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && winValid && (depth < DW'(DEPTH))) |=> (depth == $past(depth) + DW'(1)));

  // R9 end-of-interrupt pops one level
  p_eoi_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWr && (depth != '0)) |=> (depth == $past(depth) - DW'(1)));

  // R9 end-of-interrupt on an empty stack changes nothing
  p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWr && (depth == '0)) |=> (depth == '0));

  // R7 a read with no winner returns the spurious vector and keeps the depth
  p_spur_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && !winValid) |-> (busRdata == spurVec));

  p_spur_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && !winValid) |=> $stable(depth));
endmodule

bind vec_intc vec_intc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busRdata(busRdata), .irqOut(irqOut),
  .depth(stkDepth), .winValid(winValid), .spurVec(spurVec)
);

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
  localparam int NSRC = 128;
  localparam logic [7:0] A_SEL = 8'h00, A_MODE = 8'h04, A_VEC = 8'h08,
    A_ACK = 8'h10, A_CUR = 8'h18, A_MASKV = 8'h30, A_CORE = 8'h34,
    A_EOI = 8'h38, A_SPUR = 8'h3C, A_EN = 8'h40, A_DIS = 8'h44,
    A_CLR = 8'h48, A_SET = 8'h4C, A_DBG = 8'h6C;
  localparam logic [1:0] T_LOW = 2'b00, T_HIGH = 2'b01, T_FALL = 2'b10, T_RISE = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut;

  always #10 clk = ~clk;

  vec_intc u_vec_intc (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int bPri [NSRC];
  bit bEn [NSRC];
  bit bPend [NSRC];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #2 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic cfg(int idx, int pr, logic [1:0] tr, logic [31:0] v, bit enable);
    wr(A_SEL, idx);
    wr(A_MODE, 32'(pr) | (32'(tr) << 5));
    wr(A_VEC, v);
    if (enable) wr(A_EN, 1); else wr(A_DIS, 1);
  endtask

  task automatic quiet(int idx);
    wr(A_SEL, idx);
    wr(A_CLR, 1);
    wr(A_DIS, 1);
  endtask

  function automatic int expWin();
    int best = -1;
    for (int i = 0; i < NSRC; i++)
      if (bEn[i] && bPend[i] && (best < 0 || bPri[i] > bPri[best])) best = i;
    return best;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    int w;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    settle();

    // R10 reset state
    chk("R10 irq", {31'b0, irqOut}, 0);
    rd(A_SEL, r);  chk("R10 select", r, 0);
    rd(A_SPUR, r); chk("R10 spurious", r, 0);
    rd(A_DBG, r);  chk("R10 debug", r, 0);
    rd(A_MASKV, r); chk("R10 enable", r, 0);
    rd(A_MODE, r); chk("R10 mode", r, 32'h20);
    rd(A_ACK, r);  chk("R10 R7 empty ack", r, 0);
    rd(A_CORE, r); chk("R10 core", r, 0);

    // R1 select keeps seven bits
    wr(A_SEL, 32'hFFFF_FFC5); rd(A_SEL, r); chk("R1 select mask", r, 32'h45);

    // R2 mode and vector readback
    wr(A_MODE, 32'hFFFF_FF00 | 32'h66); rd(A_MODE, r); chk("R2 mode", r, 32'h66);
    wr(A_VEC, 32'hCAFE_0045); rd(A_VEC, r); chk("R2 vector", r, 32'hCAFE_0045);
    wr(A_SEL, 3); rd(A_VEC, r); chk("R1 R2 other vector", r, 0);
    wr(A_SEL, 32'h45); wr(A_MODE, 32'h20);

    // R7 spurious vector
    wr(A_SPUR, 32'h5A5A_0000);
    rd(A_ACK, r); chk("R7 spurious", r, 32'h5A5A_0000);
    rd(A_CORE, r); chk("R7 depth unchanged", r, 0);

    // R3 R4 enable, mask, force, clear
    cfg(30, 1, T_RISE, 32'h30, 1);
    wr(A_SET, 1); settle();
    chk("R4 set raises irq", {31'b0, irqOut}, 1);
    wr(A_CLR, 1); settle();
    chk("R4 clear drops irq", {31'b0, irqOut}, 0);
    wr(A_SET, 1); wr(A_DIS, 1); settle();
    chk("R3 masked no irq", {31'b0, irqOut}, 0);
    rd(A_MASKV, r); chk("R3 mask view off", r, 0);
    wr(A_SET, 0); wr(A_EN, 1); settle();
    chk("R3 enable irq", {31'b0, irqOut}, 1);
    rd(A_MASKV, r); chk("R3 mask view on", r, 1);
    wr(A_SEL, 31); rd(A_MASKV, r); chk("R3 neighbour untouched", r, 0);
    quiet(30); settle();

    // R5 level-high and level-low
    cfg(5, 1, T_HIGH, 32'h5, 1);
    srcIn[5] = 1; settle(); settle();
    chk("R5 level high on", {31'b0, irqOut}, 1);
    srcIn[5] = 0; settle(); settle();
    chk("R5 level high off", {31'b0, irqOut}, 0);
    quiet(5);
    srcIn[6] = 1;
    cfg(6, 2, T_LOW, 32'h6, 1); settle();
    chk("R5 level low idle", {31'b0, irqOut}, 0);
    srcIn[6] = 0; settle(); settle();
    chk("R5 level low active", {31'b0, irqOut}, 1);
    quiet(6); settle();

    // R5 falling edge latches
    cfg(7, 3, T_FALL, 32'h77, 1);
    srcIn[7] = 1; settle(); settle();
    chk("R5 rising ignored", {31'b0, irqOut}, 0);
    srcIn[7] = 0; settle(); settle();
    chk("R5 falling latched", {31'b0, irqOut}, 1);
    rd(A_ACK, r); chk("R6 vector", r, 32'h77);
    chk("R8 irq low after ack", {31'b0, irqOut}, 0);
    rd(A_CUR, r); chk("R8 current source", r, 7);
    wr(A_EOI, 0); settle();
    chk("R8 edge pending cleared", {31'b0, irqOut}, 0);
    quiet(7);

    // R6 tie goes to lowest index
    cfg(12, 4, T_RISE, 32'h12, 1); wr(A_SET, 1);
    cfg(9, 4, T_RISE, 32'h9, 1);   wr(A_SET, 1); settle();
    rd(A_ACK, r); chk("R6 tie lowest index", r, 32'h9);
    wr(A_EOI, 0); settle();
    chk("R6 second pending", {31'b0, irqOut}, 1);
    rd(A_ACK, r); chk("R6 next vector", r, 32'h12);
    wr(A_EOI, 0);
    quiet(12); quiet(9);

    // R11 nesting threshold
    cfg(40, 2, T_RISE, 32'h40, 1); wr(A_SET, 1); settle();
    rd(A_ACK, r); chk("R11 first ack", r, 32'h40);
    cfg(41, 2, T_RISE, 32'h41, 1); wr(A_SET, 1); settle();
    chk("R11 equal priority blocked", {31'b0, irqOut}, 0);
    cfg(42, 5, T_RISE, 32'h42, 1); wr(A_SET, 1); settle();
    chk("R11 higher priority passes", {31'b0, irqOut}, 1);
    rd(A_ACK, r); chk("R11 nested vector", r, 32'h42);
    rd(A_CUR, r); chk("R8 nested current", r, 42);
    rd(A_CORE, r); chk("R8 depth two", r, 32'h200);
    wr(A_EOI, 32'hFFFF); rd(A_CUR, r); chk("R9 pop to outer", r, 40);
    settle(); chk("R11 still blocked", {31'b0, irqOut}, 0);
    wr(A_EOI, 0); settle();
    chk("R11 released", {31'b0, irqOut}, 1);
    quiet(40); quiet(41); quiet(42); settle();

    // R9 eight nesting levels
    for (int j = 0; j < 8; j++) begin
      cfg(20 + j, j, T_RISE, 32'h2000 + j, 1);
      wr(A_SET, 1); settle();
      rd(A_ACK, r); chk("R9 nest vector", r, 32'h2000 + j);
    end
    rd(A_CORE, r); chk("R9 full depth", r, 32'h800);
    for (int j = 0; j < 8; j++) wr(A_EOI, j);
    rd(A_CORE, r); chk("R9 drained", r, 0);
    wr(A_EOI, 0); rd(A_CORE, r); chk("R9 empty pop", r, 0);
    rd(A_CUR, r); chk("R8 current empty", r, 0);
    for (int j = 0; j < 8; j++) quiet(20 + j);

    // seeded random rounds
    for (int i = 0; i < NSRC; i++) begin bPri[i] = 0; bEn[i] = 0; bPend[i] = 0; end
    for (int it = 0; it < 30; it++) begin
      int k;
      int touched [6];
      k = 1 + int'($urandom % 6);
      for (int j = 0; j < k; j++) begin
        int idx, pr;
        bit e;
        idx = int'($urandom % NSRC);
        pr  = int'($urandom % 8);
        e   = ($urandom % 4) != 0;
        touched[j] = idx;
        cfg(idx, pr, T_RISE, 32'h1000 + idx, e);
        wr(A_SET, 1);
        bPri[idx] = pr; bEn[idx] = e; bPend[idx] = 1;
      end
      settle();
      w = expWin();
      chk("R6 random irq", {31'b0, irqOut}, (w >= 0) ? 1 : 0);
      rd(A_ACK, r);
      chk("R6 R7 random vector", r, (w >= 0) ? 32'h1000 + w : 32'h5A5A_0000);
      if (w >= 0) begin
        chk("R8 random irq drop", {31'b0, irqOut}, 0);
        rd(A_CUR, r); chk("R8 random current", r, w);
        wr(A_EOI, 0);
      end
      for (int j = 0; j < k; j++) begin
        quiet(touched[j]);
        bEn[touched[j]] = 0; bPend[touched[j]] = 0;
      end
      settle();
    end

    finishRun();
  end
endmodule